// File: doc/BRIEF.md
# Bus-Matching Width Adapter with Selectable Lane Order

This block sits between a 36-bit memory word and a data port that may be 36, 18 or 9 bits wide. The word is split into four 9-bit lanes. In the wide mode every transfer moves the whole word. In the two narrow modes a word is moved as two 18-bit beats or four 9-bit beats, always through the lowest bits of the port. Two static configuration inputs select the width. An endian input selects whether the least significant part of the word travels first (little) or the most significant part travels first (big).

A 2-bit sub-counter marks the current beat position inside the word. It counts up in little-endian order and down in big-endian order, and it moves only while the burst counter is in increment mode. On the final beat of a word with increment active, the block asks the burst address logic to step to the next word, and the sub-counter returns to its start position. No new strobe is needed for that next word. Read beats return the selected lanes one cycle later, together with a per-lane output-enable mask. Write beats present a merged word and per-lane write enables, so each beat commits only its own lanes. A staging register keeps the lanes written by earlier beats.

Top module: `bm_width_adapter`

## Requirements
- R1: The width is decoded from the configuration inputs as follows. bus_match_i=0 selects x36 and ignores bus_size_i. bus_match_i=1 with bus_size_i=0 selects x18. bus_match_i=1 with bus_size_i=1 selects x9. The decoded configuration is registered, so a beat in the same cycle as a change still uses the previous configuration, and the new one applies from the next cycle.
- R2: In x36 mode big_end_i has no effect. A read beat returns the full memory word, and a write beat asserts all four lane write enables with beat_wdata_i as the word.
- R3: In x18 mode, the little-endian order moves lanes 0-1 (bits 17:0) first and lanes 2-3 (bits 35:18) second. The big-endian order reverses this. The beat travels on port bits 17:0.
- R4: In x9 mode, the little-endian lane order is 0,1,2,3 and the big-endian lane order is 3,2,1,0. Lane k is bits 9k+8:9k. The beat travels on port bits 8:0.
- R5: Read data and beat_oe_o are registered and appear one cycle after a read beat. The beat_oe_o mask is 4'b1111 for x36, 4'b0011 for x18 and 4'b0001 for x9. Port bits outside that mask read 0. After a cycle with no read beat, beat_oe_o is 0 and beat_rdata_o is 0.
- R6: A beat with beat_first_i=1 uses the start position: lane 0 for little-endian, and the last group for big-endian. This holds whatever the previous position was. A configuration change also restarts the position.
- R7: With cnt_inc_i=0, a beat leaves the position unchanged, so the next beat moves the same lanes again.
- R8: mem_addr_step_o is 1 only during the final beat of a word with cnt_inc_i=1. After that beat the position returns to the start, and the next word proceeds without beat_first_i.
- R9: A write beat asserts mem_lane_we_o only for its own lanes. mem_wdata_o carries the beat data in those lanes and the staged data from earlier beats in the other lanes, so the final beat of a narrow word presents the fully assembled word. Read beats assert no write enable.
- R10: After reset the configuration is x36 little-endian, the position is 0, and beat_oe_o and beat_rdata_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_match_i | input | 1 | 1 selects a narrow port width |
| bus_size_i | input | 1 | When narrow: 0 selects 18-bit, 1 selects 9-bit |
| big_end_i | input | 1 | 1 selects most-significant-first order |
| beat_valid_i | input | 1 | A transfer beat takes place this cycle |
| beat_write_i | input | 1 | 1 for a write beat, 0 for a read beat |
| beat_first_i | input | 1 | Address strobe: this beat starts a new word |
| cnt_inc_i | input | 1 | Burst counter is in increment mode |
| beat_wdata_i | input | 36 | Write beat data, in the low bits for narrow modes |
| beat_rdata_o | output | 36 | Registered read beat data |
| beat_oe_o | output | 4 | Registered per-lane output enable |
| mem_rdata_i | input | 36 | Memory word at the current burst address |
| mem_wdata_o | output | 36 | Merged word to memory |
| mem_lane_we_o | output | 4 | Per-lane write enables to memory |
| mem_addr_step_o | output | 1 | Advance the burst address to the next word |

## Verification
On every cycle, the assertions check how the sub-counter moves. It must hold when increment is off, step one position in the direction set by the endian select, return to the start after the word step, and never leave the range for the current width. They also check that output enables follow only read beats, that the upper lanes are never enabled outside x36, and that wide writes enable all lanes. Only the bench scenarios can show the actual lane order of data for each width and endian setting. The same applies to the assembled word after a sequence of narrow writes, the one-cycle delay of a configuration change, and the restart of a partly transferred word by a new strobe.

// File: rtl/bm_pkg.sv
package bm_pkg;
  localparam int unsigned BM_LANES = 4;
  localparam int unsigned BM_POS_W = 2;

  typedef enum logic [1:0] {
    BM_X36 = 2'd0,
    BM_X18 = 2'd1,
    BM_X9  = 2'd2
  } bm_width_e;

  typedef struct packed {
    bm_width_e width;
    logic      big;
  } bm_cfg_t;

  function automatic bm_width_e bm_decode(input logic match, input logic size);
    if (!match) return BM_X36;
    return size ? BM_X9 : BM_X18;
  endfunction

  // log2 of lanes moved per beat
  function automatic logic [1:0] bm_lane_shift(input bm_width_e w);
    case (w)
      BM_X18:  return 2'd1;
      BM_X9:   return 2'd0;
      default: return 2'd2;
    endcase
  endfunction

  function automatic logic [BM_POS_W-1:0] bm_last_pos(input bm_width_e w);
    case (w)
      BM_X18:  return 2'd1;
      BM_X9:   return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [BM_POS_W-1:0] bm_start_pos(input bm_cfg_t c);
    return c.big ? bm_last_pos(c.width) : '0;
  endfunction

  function automatic logic [BM_LANES-1:0] bm_low_mask(input bm_width_e w);
    case (w)
      BM_X18:  return 4'b0011;
      BM_X9:   return 4'b0001;
      default: return 4'b1111;
    endcase
  endfunction
endpackage

// File: rtl/bm_cfg_reg.sv
module bm_cfg_reg
  import bm_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    match_i,
  input  logic    size_i,
  input  logic    big_i,
  output bm_cfg_t cfg_o,
  output bm_cfg_t cfg_next_o,
  output logic    chg_o
);
  bm_cfg_t cfg_q;

  // endian is meaningless in x36: fold it away so toggling it does not restart
  always_comb begin
    cfg_next_o.width = bm_decode(match_i, size_i);
    cfg_next_o.big   = match_i & big_i;
  end

  assign chg_o = (cfg_next_o != cfg_q);
  assign cfg_o = cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '{width: BM_X36, big: 1'b0};
    else         cfg_q <= cfg_next_o;
  end
endmodule

// File: rtl/bm_sub_counter.sv
module bm_sub_counter
  import bm_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  bm_cfg_t             cfg_i,
  input  logic                beat_i,
  input  logic                first_i,
  input  logic                inc_i,
  input  logic                restart_i,
  input  logic [BM_POS_W-1:0] restart_pos_i,
  output logic [BM_POS_W-1:0] pos_o,
  output logic                step_o
);
  logic [BM_POS_W-1:0] sub_q, sub_d, start, pos;
  logic                at_last;

  assign start   = bm_start_pos(cfg_i);
  assign pos     = first_i ? start : sub_q;
  assign at_last = cfg_i.big ? (pos == '0) : (pos == bm_last_pos(cfg_i.width));
  assign step_o  = beat_i & inc_i & at_last;
  assign pos_o   = pos;

  always_comb begin
    if (restart_i)      sub_d = restart_pos_i;
    else if (!beat_i)   sub_d = sub_q;
    else if (!inc_i)    sub_d = pos;
    else if (at_last)   sub_d = start;
    else if (cfg_i.big) sub_d = pos - 1'b1;
    else                sub_d = pos + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sub_q <= '0;
    else         sub_q <= sub_d;
  end

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_i && !inc_i && !restart_i |=> sub_q == $past(pos));

  a_r4_advance_dir: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_i && inc_i && !at_last && !restart_i |=>
      sub_q == ($past(cfg_i.big) ? $past(pos) - 2'd1 : $past(pos) + 2'd1));

  a_r8_wrap_to_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o && !restart_i |=> sub_q == $past(start));

  a_r6_pos_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_q <= bm_last_pos(cfg_i.width));
endmodule

// File: rtl/bm_lane_router.sv
module bm_lane_router
  import bm_pkg::*;
#(
  parameter  int unsigned LANE_W = 9,
  localparam int unsigned WORD_W = LANE_W * BM_LANES
) (
  input  bm_width_e           width_i,
  input  logic [BM_POS_W-1:0] pos_i,
  input  logic [WORD_W-1:0]   wdata_i,
  input  logic [WORD_W-1:0]   stage_i,
  input  logic [WORD_W-1:0]   rdata_i,
  output logic [BM_LANES-1:0] lane_sel_o,
  output logic [WORD_W-1:0]   rd_beat_o,
  output logic [WORD_W-1:0]   wr_word_o
);
  logic [1:0]          shift;
  logic [BM_POS_W-1:0] grp_m1;

  assign shift  = bm_lane_shift(width_i);
  assign grp_m1 = BM_POS_W'((3'd1 << shift) - 3'd1);

  for (genvar g = 0; g < BM_LANES; g++) begin : g_lane
    logic [BM_POS_W-1:0] idx, grp, src_wr, src_rd;
    logic                rd_live;

    assign idx     = BM_POS_W'(g);
    assign grp     = idx >> shift;
    assign src_wr  = idx & grp_m1;
    assign src_rd  = BM_POS_W'(pos_i << shift) | idx;
    assign rd_live = (idx <= grp_m1);

    assign lane_sel_o[g] = (grp == pos_i);
    assign wr_word_o[g*LANE_W +: LANE_W] = lane_sel_o[g] ? wdata_i[src_wr*LANE_W +: LANE_W]
                                                         : stage_i[g*LANE_W +: LANE_W];
    assign rd_beat_o[g*LANE_W +: LANE_W] = rd_live ? rdata_i[src_rd*LANE_W +: LANE_W]
                                                   : '0;
  end
endmodule

// File: rtl/bm_width_adapter.sv
module bm_width_adapter
  import bm_pkg::*;
#(
  parameter  int unsigned LANE_W = 9,
  localparam int unsigned WORD_W = LANE_W * BM_LANES
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_match_i,
  input  logic                bus_size_i,
  input  logic                big_end_i,
  input  logic                beat_valid_i,
  input  logic                beat_write_i,
  input  logic                beat_first_i,
  input  logic                cnt_inc_i,
  input  logic [WORD_W-1:0]   beat_wdata_i,
  output logic [WORD_W-1:0]   beat_rdata_o,
  output logic [BM_LANES-1:0] beat_oe_o,
  input  logic [WORD_W-1:0]   mem_rdata_i,
  output logic [WORD_W-1:0]   mem_wdata_o,
  output logic [BM_LANES-1:0] mem_lane_we_o,
  output logic                mem_addr_step_o
);
  bm_cfg_t             cfg, cfg_next;
  logic                cfg_chg;
  logic [BM_POS_W-1:0] pos;
  logic [BM_LANES-1:0] lane_sel;
  logic [WORD_W-1:0]   rd_beat, wr_word, stage_q, rdata_q;
  logic [BM_LANES-1:0] oe_q;
  logic                rd_beat_v, wr_beat_v;

  assign rd_beat_v = beat_valid_i & ~beat_write_i;
  assign wr_beat_v = beat_valid_i &  beat_write_i;

  bm_cfg_reg u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .match_i    (bus_match_i),
    .size_i     (bus_size_i),
    .big_i      (big_end_i),
    .cfg_o      (cfg),
    .cfg_next_o (cfg_next),
    .chg_o      (cfg_chg)
  );

  bm_sub_counter u_sub (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cfg_i         (cfg),
    .beat_i        (beat_valid_i),
    .first_i       (beat_first_i),
    .inc_i         (cnt_inc_i),
    .restart_i     (cfg_chg),
    .restart_pos_i (bm_start_pos(cfg_next)),
    .pos_o         (pos),
    .step_o        (mem_addr_step_o)
  );

  bm_lane_router #(.LANE_W(LANE_W)) u_route (
    .width_i    (cfg.width),
    .pos_i      (pos),
    .wdata_i    (beat_wdata_i),
    .stage_i    (stage_q),
    .rdata_i    (mem_rdata_i),
    .lane_sel_o (lane_sel),
    .rd_beat_o  (rd_beat),
    .wr_word_o  (wr_word)
  );

  assign mem_wdata_o   = wr_word;
  assign mem_lane_we_o = wr_beat_v ? lane_sel : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      rdata_q <= '0;
      oe_q    <= '0;
    end else begin
      if (wr_beat_v) stage_q <= wr_word;
      rdata_q <= rd_beat_v ? rd_beat : '0;
      oe_q    <= rd_beat_v ? bm_low_mask(cfg.width) : '0;
    end
  end

  assign beat_rdata_o = rdata_q;
  assign beat_oe_o    = oe_q;

  a_r5_oe_follows_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_oe_o != '0 |-> $past(beat_valid_i && !beat_write_i));

  a_r5_upper_oe_wide_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_oe_o[BM_LANES-1] |-> $past(cfg.width) == BM_X36);

  a_r2_wide_write_all_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg.width == BM_X36 && wr_beat_v |-> mem_lane_we_o == '1);
endmodule

// File: tb/bm_width_adapter_tb.sv
module bm_width_adapter_tb;
  localparam int LW = 9;
  localparam int WW = 36;
  localparam logic [WW-1:0] RWORD = 36'hD_2C4B_7A19;

  logic clk, rst_n;
  logic bus_match, bus_size, big_end, beat_valid, beat_write, beat_first, cnt_inc;
  logic [WW-1:0] beat_wdata, beat_rdata, mem_rdata, mem_wdata;
  logic [3:0]    beat_oe, mem_lane_we;
  logic          mem_addr_step;

  bm_width_adapter u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_match_i(bus_match), .bus_size_i(bus_size), .big_end_i(big_end),
    .beat_valid_i(beat_valid), .beat_write_i(beat_write), .beat_first_i(beat_first),
    .cnt_inc_i(cnt_inc), .beat_wdata_i(beat_wdata), .beat_rdata_o(beat_rdata),
    .beat_oe_o(beat_oe), .mem_rdata_i(mem_rdata), .mem_wdata_o(mem_wdata),
    .mem_lane_we_o(mem_lane_we), .mem_addr_step_o(mem_addr_step)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [3:0]    s_we, s_oe;
  logic [WW-1:0] s_wd, s_rd;
  logic          s_st;

  task automatic chk(input string tag, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [WW-1:0] exp_rd(input logic [3:0] m);
    int lo = 0;
    int n  = $countones(m);
    if (m == 4'd0) return '0;
    for (int i = 3; i >= 0; i--) if (m[i]) lo = i;
    return (RWORD >> (lo*LW)) & ((WW'(1) << (n*LW)) - WW'(1));
  endfunction

  function automatic logic [3:0] exp_oe(input logic [3:0] m);
    return (4'd1 << $countones(m)) - 4'd1;
  endfunction

  task automatic run_beat(input logic bm, input logic sz, input logic bg, input logic v,
                          input logic w, input logic f, input logic inc,
                          input logic [WW-1:0] wd);
    @(negedge clk);
    bus_match = bm; bus_size = sz; big_end = bg;
    beat_valid = v; beat_write = w; beat_first = f; cnt_inc = inc; beat_wdata = wd;
    #5;
    s_we = mem_lane_we; s_wd = mem_wdata; s_st = mem_addr_step;
    @(posedge clk);
    #1;
    s_rd = beat_rdata; s_oe = beat_oe;
  endtask

  typedef struct packed {
    logic bm, sz, bg, first, inc;
    logic [3:0] lanes;
    logic step;
    logic [1:0] kind; // 0 plain, 1 restart, 2 hold
  } vec_t;

  localparam int NV = 36;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,1'b0,1'b1,1'b1,4'hF,1'b1,2'd0}, // R2 x36 little
    '{1'b0,1'b0,1'b0,1'b0,1'b1,4'hF,1'b1,2'd0},
    '{1'b0,1'b0,1'b1,1'b0,1'b1,4'hF,1'b1,2'd0}, // R2 endian ignored
    '{1'b0,1'b0,1'b1,1'b1,1'b0,4'hF,1'b0,2'd2}, // R7 no step without inc
    '{1'b1,1'b0,1'b0,1'b1,1'b1,4'h3,1'b0,2'd0}, // R3 x18 little
    '{1'b1,1'b0,1'b0,1'b0,1'b1,4'hC,1'b1,2'd0},
    '{1'b1,1'b0,1'b0,1'b0,1'b1,4'h3,1'b0,2'd0}, // R8 next word without strobe
    '{1'b1,1'b0,1'b0,1'b0,1'b1,4'hC,1'b1,2'd0},
    '{1'b1,1'b0,1'b1,1'b1,1'b1,4'hC,1'b0,2'd0}, // R3 x18 big
    '{1'b1,1'b0,1'b1,1'b0,1'b1,4'h3,1'b1,2'd0},
    '{1'b1,1'b0,1'b1,1'b0,1'b1,4'hC,1'b0,2'd0},
    '{1'b1,1'b1,1'b0,1'b1,1'b1,4'h1,1'b0,2'd0}, // R4 x9 little
    '{1'b1,1'b1,1'b0,1'b0,1'b1,4'h2,1'b0,2'd0},
    '{1'b1,1'b1,1'b0,1'b0,1'b1,4'h4,1'b0,2'd0},
    '{1'b1,1'b1,1'b0,1'b0,1'b1,4'h8,1'b1,2'd0},
    '{1'b1,1'b1,1'b0,1'b0,1'b1,4'h1,1'b0,2'd0},
    '{1'b1,1'b1,1'b1,1'b1,1'b1,4'h8,1'b0,2'd0}, // R4 x9 big
    '{1'b1,1'b1,1'b1,1'b0,1'b1,4'h4,1'b0,2'd0},
    '{1'b1,1'b1,1'b1,1'b0,1'b1,4'h2,1'b0,2'd0},
    '{1'b1,1'b1,1'b1,1'b0,1'b1,4'h1,1'b1,2'd0},
    '{1'b1,1'b1,1'b1,1'b0,1'b0,4'h8,1'b0,2'd2}, // R7 hold
    '{1'b1,1'b1,1'b1,1'b0,1'b0,4'h8,1'b0,2'd2},
    '{1'b1,1'b1,1'b1,1'b0,1'b1,4'h8,1'b0,2'd0},
    '{1'b1,1'b1,1'b1,1'b0,1'b1,4'h4,1'b0,2'd0},
    '{1'b1,1'b1,1'b1,1'b1,1'b1,4'h8,1'b0,2'd1}, // R6 restart mid-word
    '{1'b1,1'b1,1'b1,1'b0,1'b0,4'h4,1'b0,2'd2},
    '{1'b1,1'b1,1'b0,1'b1,1'b1,4'h1,1'b0,2'd0},
    '{1'b1,1'b1,1'b0,1'b0,1'b1,4'h2,1'b0,2'd0},
    '{1'b1,1'b1,1'b0,1'b1,1'b0,4'h1,1'b0,2'd1}, // R6 restart little
    '{1'b1,1'b1,1'b0,1'b0,1'b0,4'h1,1'b0,2'd2},
    '{1'b1,1'b0,1'b0,1'b1,1'b1,4'h3,1'b0,2'd0},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,4'hC,1'b0,2'd2}, // R8 last beat, no inc
    '{1'b1,1'b0,1'b0,1'b0,1'b0,4'hC,1'b0,2'd2},
    '{1'b1,1'b0,1'b0,1'b0,1'b1,4'hC,1'b1,2'd0},
    '{1'b1,1'b0,1'b0,1'b0,1'b1,4'h3,1'b0,2'd0},
    '{1'b0,1'b1,1'b0,1'b1,1'b1,4'hF,1'b1,2'd0}  // R1 size ignored when not matched
  };

  function automatic string mode_tag(input logic [3:0] lanes);
    if (lanes == 4'hF) return "R2 wide read";
    if ($countones(lanes) == 2) return "R3 x18 read";
    return "R4 x9 read";
  endfunction

  function automatic string kind_tag(input logic [1:0] k);
    if (k == 2'd1) return "R6 restart lanes";
    if (k == 2'd2) return "R7 hold lanes";
    return "R1 decode lanes";
  endfunction

  initial begin
    #4_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [2:0] prev_cfg;
    logic [8:0] d [4];
    logic [17:0] hw0, hw1;
    rst_n = 1'b0;
    bus_match = 0; bus_size = 0; big_end = 0; beat_valid = 0; beat_write = 0;
    beat_first = 0; cnt_inc = 0; beat_wdata = '0; mem_rdata = RWORD;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset oe", WW'(beat_oe), '0);
    chk("R10 reset rdata", beat_rdata, '0);
    @(negedge clk);
    rst_n = 1'b1;

    run_beat(0,0,0,0,0,0,0,'0);
    chk("R10 idle oe", WW'(s_oe), '0);
    chk("R10 idle step", WW'(s_st), '0);
    chk("R10 idle rdata", s_rd, '0);

    prev_cfg = 3'b000;
    for (int i = 0; i < NV; i++) begin
      vec_t t;
      t = VECS[i];
      if ({t.bm, t.sz, t.bg} != prev_cfg) begin
        run_beat(t.bm, t.sz, t.bg, 0, 0, 0, 0, '0);
        chk("R5 oe idle after config change", WW'(s_oe), '0);
        prev_cfg = {t.bm, t.sz, t.bg};
      end
      run_beat(t.bm, t.sz, t.bg, 1, 0, t.first, t.inc, '0);
      chk(mode_tag(t.lanes), s_rd, exp_rd(t.lanes));
      chk(kind_tag(t.kind), s_rd, exp_rd(t.lanes));
      chk("R5 oe mask", WW'(s_oe), WW'(exp_oe(t.lanes)));
      chk("R8 word step", WW'(s_st), WW'(t.step));
      chk("R9 read has no write enable", WW'(s_we), '0);
    end

    // R1: change presented with a beat uses the old width for that beat
    run_beat(1,1,0,0,0,0,0,'0);
    run_beat(1,0,0,1,0,1,1,'0);
    chk("R1 old width on change cycle", s_rd, exp_rd(4'h1));
    run_beat(1,0,0,1,0,1,1,'0);
    chk("R1 new width next cycle", s_rd, exp_rd(4'h3));

    // R9 x9 little writes
    d[0] = 9'h1A5; d[1] = 9'h03C; d[2] = 9'h150; d[3] = 9'h0E7;
    run_beat(1,1,0,0,0,0,0,'0);
    for (int k = 0; k < 4; k++) begin
      run_beat(1,1,0,1,1,(k == 0),1,{27'h7FF_FFFF, d[k]});
      chk("R9 x9 little lane we", WW'(s_we), WW'(4'd1 << k));
      chk("R4 x9 little write lane", WW'(s_wd[k*LW +: LW]), WW'(d[k]));
      chk("R8 write step", WW'(s_st), WW'(k == 3));
    end
    chk("R9 x9 little assembled", s_wd, {d[3], d[2], d[1], d[0]});
    chk("R5 no oe after write", WW'(s_oe), '0);

    // R9 x9 big writes
    run_beat(1,1,1,0,0,0,0,'0);
    for (int k = 0; k < 4; k++) begin
      run_beat(1,1,1,1,1,(k == 0),1,{27'h0, d[k]});
      chk("R9 x9 big lane we", WW'(s_we), WW'(4'd8 >> k));
      chk("R4 x9 big write lane", WW'(s_wd[(3-k)*LW +: LW]), WW'(d[k]));
    end
    chk("R9 x9 big assembled", s_wd, {d[0], d[1], d[2], d[3]});

    // R3 x18 big writes
    hw0 = 18'h2_B3C1; hw1 = 18'h1_0F5E;
    run_beat(1,0,1,0,0,0,0,'0);
    run_beat(1,0,1,1,1,1,1,{18'h3_FFFF, hw0});
    chk("R3 x18 big first we", WW'(s_we), WW'(4'hC));
    chk("R3 x18 big first lanes", WW'(s_wd[35:18]), WW'(hw0));
    run_beat(1,0,1,1,1,0,1,{18'h0, hw1});
    chk("R3 x18 big second we", WW'(s_we), WW'(4'h3));
    chk("R9 x18 big assembled", s_wd, {hw0, hw1});

    // R2 wide write, endian input set but ignored
    run_beat(0,0,1,0,0,0,0,'0);
    run_beat(0,0,1,1,1,1,1,36'hA_5A5A_5A5A);
    chk("R2 wide write we", WW'(s_we), WW'(4'hF));
    chk("R2 wide write data", s_wd, 36'hA_5A5A_5A5A);
    chk("R8 wide write step", WW'(s_st), WW'(1));

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule